// File: doc/BRIEF.md
# Reference Code Ramp Sequencer

This block generates the 7-bit code that feeds a regulator's reference DAC. Code 0 means the output is off. Any nonzero code selects a voltage that starts at the lowest level and rises by one LSB per code up to code 78. The LSB weight is chosen outside this block. The rates are expressed in code steps per unit time, and those stay the same for either LSB weight. For that reason the weight select never enters this block's timing.

When enable rises, the block waits a fixed start-up delay and then soft-starts from zero toward the requested target. After that it follows any change of target at a separate tracking rate. When enable falls, it walks the code back down to zero at the slowest rate. The requested target is clamped to a programmable ceiling and to the top legal code. A registered flag reports a request above the ceiling. A slewing flag shows that the code has not yet reached where it is heading.

All pins are plain level signals sampled on the rising clock edge. There is no data stream and no handshake. The timing is set by two parameters: `HALF_STEP_CYC`, the clock cycles per code step at the fastest rate, and `START_DELAY_CYC`, the clock cycles of the start-up wait.

Top module: `volt_ramp_ctrl`

## Requirements
- R1: After reset, and at any time while the sequencer is idle with enable low, `code` is 0 and both `slewing` and `max_err` are 0.
- R2: When enable is sampled high from idle, `code` stays 0 and `slewing` is 1 for `START_DELAY_CYC` cycles. The first step, to code 1, lands `START_DELAY_CYC` plus one soft-start period after the sampling edge.
- R3: The code heads for the smallest of `target_code`, `max_code` and 78, and settles exactly there.
- R4: `max_err` is 1 in the cycle after a clock edge that sees enable high and `target_code` greater than `max_code`. Otherwise it is 0.
- R5: During soft-start the code moves one step per period. The period is `HALF_STEP_CYC` times a multiplier picked by `slew_sel`. For codes 0 to 9 the soft-start multipliers are 2, 4, 8, 4, 8, 1, 2, 4, 8, 8 (multiplier 1 is the fastest rate, 8 the slowest).
- R6: Once soft-start has reached its goal, a change of target is followed one step per period. That period is `HALF_STEP_CYC` times the tracking multiplier for `slew_sel` codes 0 to 9: 2, 2, 2, 4, 4, 1, 1, 1, 1, 8.
- R7: `slew_sel` codes 10 to 15 use multiplier 8 for both soft-start and tracking.
- R8: When enable is sampled low after start-up, the code falls by one every `8*HALF_STEP_CYC` cycles until it reaches 0, and then the block is idle.
- R9: If enable returns high during the ramp-down, the code climbs again at the soft-start rate from the value it holds, with no start-up delay. The first up-step comes one soft-start period after the edge that samples enable.
- R10: `slewing` is 1 during the start-up wait and whenever `code` differs from its current goal. The goal is the clamped target while running and 0 while ramping down. `slewing` is 0 once the code has settled.
- R11: Enable dropped during the start-up wait returns the block to idle with no code step. A later enable starts a fresh wait.
- R12: `code` never changes by more than one per clock and never exceeds 78.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Output enable; high starts up, low ramps down |
| target_code | input | 7 | Requested reference code |
| max_code | input | 7 | Ceiling applied to the request |
| slew_sel | input | 4 | Rate pair select for soft-start and tracking |
| code | output | 7 | Present reference code |
| slewing | output | 1 | Code not yet at its goal, or start-up wait in progress |
| max_err | output | 1 | Registered flag: request above the ceiling |

## Verification
The assertions assume that every input is synchronous to `clk` and that `HALF_STEP_CYC` is at least 2. Under that assumption, no two code steps can fall on back-to-back cycles. They also assume that a phase change is seen only through the registered enable and code values. The bench respects this by changing every input on the falling clock edge only. It also overrides the two timing parameters with small values (3 and 10) that still satisfy those bounds. Targets, ceilings and rate selects are changed only after the code has settled, with one exception: the re-enable is issued deliberately in the middle of a ramp-down.

// File: rtl/volt_ramp_pkg.sv
package volt_ramp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WAIT = 3'd1,
    PH_RISE = 3'd2,
    PH_HOLD = 3'd3,
    PH_FALL = 3'd4
  } phase_t;

  // Period exponent: step period = base << exponent (0 fastest, 3 slowest)
  localparam logic [1:0] SLOWEST_EXP = 2'd3;

  function automatic logic [1:0] rise_exp_f(input logic [3:0] sel);
    case (sel)
      4'd0:    rise_exp_f = 2'd1;
      4'd1:    rise_exp_f = 2'd2;
      4'd2:    rise_exp_f = 2'd3;
      4'd3:    rise_exp_f = 2'd2;
      4'd4:    rise_exp_f = 2'd3;
      4'd5:    rise_exp_f = 2'd0;
      4'd6:    rise_exp_f = 2'd1;
      4'd7:    rise_exp_f = 2'd2;
      4'd8:    rise_exp_f = 2'd3;
      default: rise_exp_f = SLOWEST_EXP;
    endcase
  endfunction

  function automatic logic [1:0] track_exp_f(input logic [3:0] sel);
    case (sel)
      4'd0, 4'd1, 4'd2:       track_exp_f = 2'd1;
      4'd3, 4'd4:             track_exp_f = 2'd2;
      4'd5, 4'd6, 4'd7, 4'd8: track_exp_f = 2'd0;
      default:                track_exp_f = SLOWEST_EXP;
    endcase
  endfunction

endpackage

// File: rtl/vr_rate_map.sv
module vr_rate_map
  import volt_ramp_pkg::*;
(
  input  logic [3:0] slew_sel,
  output logic [1:0] rise_exp,
  output logic [1:0] track_exp
);

  always_comb begin
    rise_exp  = rise_exp_f(slew_sel);
    track_exp = track_exp_f(slew_sel);
  end

endmodule

// File: rtl/vr_goal_clamp.sv
module vr_goal_clamp #(
  parameter int CODE_W    = 7,
  parameter int LAST_CODE = 78
) (
  input  logic [CODE_W-1:0] target_code,
  input  logic [CODE_W-1:0] max_code,
  output logic [CODE_W-1:0] goal
);

  localparam logic [CODE_W-1:0] TOP = CODE_W'(LAST_CODE);

  logic [CODE_W-1:0] ceil_code;

  always_comb begin
    ceil_code = (max_code < TOP) ? max_code : TOP;
    goal      = (target_code > ceil_code) ? ceil_code : target_code;
  end

endmodule

// File: rtl/vr_step_timer.sv
module vr_step_timer #(
  parameter int HALF_STEP_CYC = 57
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [1:0] period_exp,
  output logic       step
);

  localparam int MAX_PER = HALF_STEP_CYC * 8;
  localparam int CNT_W   = $clog2(MAX_PER + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    last_cnt = (CNT_W'(HALF_STEP_CYC) << period_exp) - CNT_W'(1);
    step     = run && !clr && (cnt_q >= last_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || !run) cnt_q <= '0;
    else if (step)       cnt_q <= '0;
    else                 cnt_q <= cnt_q + CNT_W'(1);
  end

  // Requires HALF_STEP_CYC >= 2: consecutive steps never touch
  AST_STEP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step); // R5

endmodule

// File: rtl/volt_ramp_ctrl.sv
module volt_ramp_ctrl
  import volt_ramp_pkg::*;
#(
  parameter int CODE_W          = 7,
  parameter int LAST_CODE       = 78,
  parameter int HALF_STEP_CYC   = 57,
  parameter int START_DELAY_CYC = 35000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] target_code,
  input  logic [CODE_W-1:0] max_code,
  input  logic [3:0]        slew_sel,
  output logic [CODE_W-1:0] code,
  output logic              slewing,
  output logic              max_err
);

  localparam int DLY_W = $clog2(START_DELAY_CYC + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(START_DELAY_CYC - 1);

  phase_t phase_q, phase_nx;
  logic [DLY_W-1:0]  dly_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] goal;
  logic [CODE_W-1:0] aim;
  logic [1:0]        rise_exp, track_exp, sel_exp;
  logic              at_aim, moving, phase_chg, step;
  logic              err_q;

  vr_rate_map u_rates (
    .slew_sel  (slew_sel),
    .rise_exp  (rise_exp),
    .track_exp (track_exp)
  );

  vr_goal_clamp #(.CODE_W(CODE_W), .LAST_CODE(LAST_CODE)) u_clamp (
    .target_code (target_code),
    .max_code    (max_code),
    .goal        (goal)
  );

  always_comb begin
    aim    = (phase_q == PH_RISE || phase_q == PH_HOLD) ? goal : '0;
    at_aim = (code_q == aim);
    moving = (phase_q == PH_RISE || phase_q == PH_HOLD || phase_q == PH_FALL) && !at_aim;
    case (phase_q)
      PH_RISE: sel_exp = rise_exp;
      PH_HOLD: sel_exp = track_exp;
      default: sel_exp = SLOWEST_EXP;
    endcase
  end

  always_comb begin
    phase_nx = phase_q;
    case (phase_q)
      PH_IDLE: if (en) phase_nx = PH_WAIT;
      PH_WAIT: begin
        if (!en)                   phase_nx = PH_IDLE;
        else if (dly_q == DLY_LAST) phase_nx = PH_RISE;
      end
      PH_RISE: begin
        if (!en)         phase_nx = PH_FALL;
        else if (at_aim) phase_nx = PH_HOLD;
      end
      PH_HOLD: if (!en) phase_nx = PH_FALL;
      PH_FALL: begin
        if (en)                  phase_nx = PH_RISE;
        else if (code_q == '0)   phase_nx = PH_IDLE;
      end
      default: phase_nx = PH_IDLE;
    endcase
    phase_chg = (phase_nx != phase_q);
  end

  vr_step_timer #(.HALF_STEP_CYC(HALF_STEP_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (phase_chg),
    .run        (moving),
    .period_exp (sel_exp),
    .step       (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      dly_q   <= '0;
      code_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_nx;
      dly_q   <= (phase_q == PH_WAIT && phase_nx == PH_WAIT) ? dly_q + DLY_W'(1) : '0;
      if (step) code_q <= (code_q < aim) ? code_q + CODE_W'(1) : code_q - CODE_W'(1);
      err_q   <= en && (target_code > max_code);
    end
  end

  assign code    = code_q;
  assign slewing = (phase_q == PH_WAIT) || !at_aim;
  assign max_err = err_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> (code_q == '0 && !slewing)); // R1
  AST_WAIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) |-> (code_q == '0)); // R2
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, code_q} == {1'b0, $past(code_q)}) ||
    ({1'b0, code_q} == {1'b0, $past(code_q)} + 1'b1) ||
    ({1'b0, code_q} + 1'b1 == {1'b0, $past(code_q)})); // R12
  AST_CODE_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= CODE_W'(LAST_CODE)); // R12
  AST_FALL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FALL && $past(phase_q) == PH_FALL) |-> (code_q <= $past(code_q))); // R8
  AST_HOLD_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD && $past(phase_q) == PH_RISE) |-> ($past(code_q) == $past(aim))); // R10

endmodule

// File: tb/tb_volt_ramp_ctrl.sv
module tb_volt_ramp_ctrl;
  localparam int H = 3;
  localparam int D = 10;
  localparam int TOPC = 78;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [6:0] target_code = 7'd0;
  logic [6:0] max_code = 7'd78;
  logic [3:0] slew_sel = 4'd0;
  wire  [6:0] code;
  wire        slewing, max_err;

  volt_ramp_ctrl #(.HALF_STEP_CYC(H), .START_DELAY_CYC(D)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .target_code(target_code),
    .max_code(max_code), .slew_sel(slew_sel), .code(code),
    .slewing(slewing), .max_err(max_err));

  always #2 clk = ~clk;

  typedef struct { int val; int gap; string req; } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0, cyc = 0, last_chg = 0;
  logic [6:0] prev_code = 7'd0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rise_per(int s);
    case (s)
      0: return 2*H; 1: return 4*H; 2: return 8*H; 3: return 4*H; 4: return 8*H;
      5: return H;   6: return 2*H; 7: return 4*H; 8: return 8*H; 9: return 8*H;
      default: return 8*H;
    endcase
  endfunction

  function automatic int track_per(int s);
    case (s)
      0, 1, 2: return 2*H;
      3, 4: return 4*H;
      5, 6, 7, 8: return H;
      default: return 8*H;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Driver side: push the expected code sequence from 'from' to 'to'
  task automatic push_ramp(int from, int to, int first_gap, int gap, string req);
    int v = from;
    bit first = 1'b1;
    while (v != to) begin
      exp_t e;
      v = (to > v) ? v + 1 : v - 1;
      e.val = v; e.gap = first ? first_gap : gap; e.req = req;
      q.push_back(e);
      first = 1'b0;
    end
  endtask

  // Monitor: pop and compare on every code change
  always @(negedge clk) begin
    if (rst_n && code !== prev_code) begin
      if (q.size() == 0) chk(1'b0, "R12", "unexpected code change", int'(code), int'(prev_code));
      else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(code) == e.val, e.req, "code value", int'(code), e.val);
        if (e.gap >= 0) chk(cyc - last_chg == e.gap, e.req, "step gap", cyc - last_chg, e.gap);
      end
      last_chg = cyc;
      prev_code = code;
    end
  end

  task automatic drain(string req, int settled);
    while (q.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(int'(code) == settled, req, "settled code", int'(code), settled);
    chk(slewing == 1'b0, "R10", "slewing after settle", int'(slewing), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(code == 7'd0, "R1", "code after reset", int'(code), 0);
    chk(slewing == 1'b0, "R1", "slewing after reset", int'(slewing), 0);
    chk(max_err == 1'b0, "R1", "max_err after reset", int'(max_err), 0);

    // R2 R5: start-up wait then soft-start at slew code 0
    target_code = 7'd6;
    push_ramp(0, 6, D + rise_per(0), rise_per(0), "R5");
    en = 1'b1; last_chg = cyc + 1;
    @(negedge clk);
    chk(slewing == 1'b1, "R2", "slewing in wait", int'(slewing), 1);
    repeat (D - 1) @(negedge clk);
    chk(code == 7'd0, "R2", "code at end of wait", int'(code), 0);
    drain("R5", 6);

    // R8 R9: ramp down, re-enable mid-way
    en = 1'b0;
    push_ramp(6, 4, -1, 8*H, "R8");
    do @(negedge clk); while (code != 7'd4);
    en = 1'b1;
    push_ramp(4, 6, rise_per(0) + 1, rise_per(0), "R9");
    drain("R9", 6);

    // R6: tracking at slew code 3, up then down
    slew_sel = 4'd3; target_code = 7'd9;
    push_ramp(6, 9, -1, track_per(3), "R6");
    drain("R6", 9);
    target_code = 7'd7;
    push_ramp(9, 7, -1, track_per(3), "R6");
    drain("R6", 7);

    // R3 R4: ceiling clamp and error flag
    slew_sel = 4'd5;
    push_ramp(7, 8, -1, track_per(5), "R3");
    max_code = 7'd8; target_code = 7'd20;
    @(negedge clk);
    chk(max_err == 1'b1, "R4", "max_err over ceiling", int'(max_err), 1);
    drain("R3", 8);
    max_code = 7'h7F; target_code = 7'h7F;
    push_ramp(8, TOPC, -1, track_per(5), "R3");
    @(negedge clk);
    chk(max_err == 1'b0, "R4", "max_err at equal", int'(max_err), 0);
    drain("R3", TOPC);

    // R7: reserved slew code uses slowest rate
    slew_sel = 4'd12; target_code = 7'd75;
    push_ramp(TOPC, 75, -1, 8*H, "R7");
    drain("R7", 75);
    slew_sel = 4'd5; target_code = 7'd4;
    push_ramp(75, 4, -1, track_per(5), "R6");
    drain("R6", 4);

    // R8: complete ramp-down at slowest rate despite fast select
    en = 1'b0;
    push_ramp(4, 0, -1, 8*H, "R8");
    drain("R8", 0);
    chk(max_err == 1'b0, "R1", "max_err idle", int'(max_err), 0);

    // R11: short enable inside the wait
    en = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b0;
    repeat (3 * D) @(negedge clk);
    chk(code == 7'd0, "R11", "code after aborted wait", int'(code), 0);
    chk(slewing == 1'b0, "R11", "slewing after aborted wait", int'(slewing), 0);

    // R5: soft-start at slowest select, then R8 shutdown
    slew_sel = 4'd8; target_code = 7'd3;
    push_ramp(0, 3, D + rise_per(8), rise_per(8), "R5");
    en = 1'b1; last_chg = cyc + 1;
    drain("R5", 3);
    en = 1'b0;
    push_ramp(3, 0, -1, 8*H, "R8");
    drain("R8", 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule